// File: doc/BRIEF.md
# Register Read-Modify-Write Configuration Sequencer

This block brings an angle sensor into a known configuration after power-up. A single start pulse makes it walk a fixed, ordered list of five configuration registers. For each register it asks a transaction engine to read the register. When the value comes back, it clears a fixed set of bits, forces a fixed set of bits high, and asks the engine to write the merged word back to the same address.

The sequencer never has more than one request outstanding. A request is held steady until the engine answers with a done flag. The engine returns an error code with every answer. A nonzero code stops the walk on the spot, and no further requests are issued. When the walk ends, either completed or aborted, the sequencer raises a one-cycle done pulse and shows a pass/fail result. That result holds until the next start.

Top module: `rmw_cfg_seq`

## Requirements
- R1: While reset is high and right after it is released, busy, done, request and pass are all low.
- R2: A start pulse seen while idle raises busy on the next cycle. In that same cycle it issues a read request (write flag low) to address 0x06.
- R3: The registers are visited in the order 0x06, 0x08, 0x09, 0x0D, 0x0E. Each visit is a read of the address followed by a write to the same address, so a completed run answers exactly ten transactions. The write flag is 1 for a write and 0 for a read.
- R4: The written word is (read word AND NOT clear) OR force. The clear/force pairs are 0x6017/0x2001 for 0x06, 0x3FFF/0x3FF1 for 0x08, 0x000F/0x0000 for 0x09, 0x000F/0x000B for 0x0D, and 0x00FF/0x0010 for 0x0E.
- R5: A request keeps its address, write flag and write data stable until the engine's done flag is seen. A write is issued only after the read of the same register has completed.
- R6: When all ten transactions return error code zero, done pulses for exactly one cycle with pass high, and busy falls in the cycle after the pulse.
- R7: On the first transaction that returns a nonzero error code, the request drops in the next cycle. Done then pulses with pass low, and no further request is issued.
- R8: A start pulse that arrives while busy is high has no effect on the running walk and does not queue a second run.
- R9: Pass keeps its value after a run ends until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for one configuration walk |
| busy_o | output | 1 | High from the cycle after start through the done pulse |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| pass_o | output | 1 | Result of the last walk: 1 = every transaction returned no error |
| req_o | output | 1 | Transaction request, held until rsp_done_i |
| req_we_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 8 | Register address of the request |
| req_wdata_o | output | 16 | Merged word for a write request |
| rsp_done_i | input | 1 | Engine finished the current request |
| rsp_rdata_i | input | 16 | Read word, valid with rsp_done_i on a read |
| rsp_err_i | input | ERR_W (3) | Error code, valid with rsp_done_i; zero means success |

## Verification
The bench builds the block with its default error-code width of three bits. This allows distinct nonzero codes (1, 5 and 7) to be injected, and shows that any nonzero value aborts, not just one bit. The behavioural engine model answers with one-cycle and three-cycle latencies, so held requests and back-to-back read-to-write hand-over are both exercised. Error injection at the first read, a middle write and the last write reaches every abort point in the walk.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int unsigned CS_ADDR_W    = 8;
    localparam int unsigned CS_DATA_W    = 16;
    localparam int unsigned CS_N_ENTRIES = 5;
    localparam int unsigned CS_IDX_W     = $clog2(CS_N_ENTRIES);

    typedef struct packed {
        logic [CS_ADDR_W-1:0] addr;
        logic [CS_DATA_W-1:0] clr;
        logic [CS_DATA_W-1:0] force_bits;
    } cfg_entry_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2,
        SEQ_END   = 2'd3
    } seq_state_t;

    // Ordered configuration list; position in the walk is the index.
    function automatic cfg_entry_t entry_at(input int unsigned i);
        cfg_entry_t e;
        case (i)
            0:       e = '{addr: 8'h06, clr: 16'h6017, force_bits: 16'h2001};
            1:       e = '{addr: 8'h08, clr: 16'h3FFF, force_bits: 16'h3FF1};
            2:       e = '{addr: 8'h09, clr: 16'h000F, force_bits: 16'h0000};
            3:       e = '{addr: 8'h0D, clr: 16'h000F, force_bits: 16'h000B};
            4:       e = '{addr: 8'h0E, clr: 16'h00FF, force_bits: 16'h0010};
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic [CS_DATA_W-1:0] merge_word(
        input logic [CS_DATA_W-1:0] rd,
        input logic [CS_DATA_W-1:0] clr,
        input logic [CS_DATA_W-1:0] fb
    );
        return (rd & ~clr) | fb;
    endfunction

endpackage

// File: rtl/cfgseq_table.sv
module cfgseq_table
    import cfgseq_pkg::*;
(
    input  logic [CS_IDX_W-1:0] idx_i,
    output cfg_entry_t          entry_o
);
    cfg_entry_t rom [CS_N_ENTRIES];

    for (genvar g = 0; g < CS_N_ENTRIES; g++) begin : g_rom
        assign rom[g] = entry_at(g);
    end

    always_comb begin
        if (idx_i < CS_IDX_W'(CS_N_ENTRIES)) entry_o = rom[idx_i];
        else                                 entry_o = '0;
    end
endmodule

// File: rtl/cfgseq_merge.sv
module cfgseq_merge
    import cfgseq_pkg::*;
(
    input  logic [CS_DATA_W-1:0] rdata_i,
    input  logic [CS_DATA_W-1:0] clr_i,
    input  logic [CS_DATA_W-1:0] force_i,
    output logic [CS_DATA_W-1:0] merged_o
);
    assign merged_o = merge_word(rdata_i, clr_i, force_i);
endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
    import cfgseq_pkg::*;
#(
    parameter int unsigned ERR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 rsp_done_i,
    input  logic [ERR_W-1:0]     rsp_err_i,
    input  logic [CS_DATA_W-1:0] merged_i,
    output logic [CS_IDX_W-1:0]  idx_o,
    output logic [CS_DATA_W-1:0] wdata_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 pass_o,
    output logic                 req_o,
    output logic                 req_we_o
);
    localparam logic [CS_IDX_W-1:0] LAST_IDX = CS_IDX_W'(CS_N_ENTRIES - 1);

    seq_state_t           state_q;
    logic [CS_IDX_W-1:0]  idx_q;
    logic [CS_DATA_W-1:0] wdata_q;
    logic                 pass_q;
    logic                 rsp_bad;

    assign rsp_bad = (rsp_err_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            wdata_q <= '0;
            pass_q  <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SEQ_READ;
                        idx_q   <= '0;
                        pass_q  <= 1'b0;
                    end
                end
                SEQ_READ: begin
                    if (rsp_done_i) begin
                        if (rsp_bad) begin
                            state_q <= SEQ_END;
                            pass_q  <= 1'b0;
                        end else begin
                            wdata_q <= merged_i;
                            state_q <= SEQ_WRITE;
                        end
                    end
                end
                SEQ_WRITE: begin
                    if (rsp_done_i) begin
                        if (rsp_bad) begin
                            state_q <= SEQ_END;
                            pass_q  <= 1'b0;
                        end else if (idx_q == LAST_IDX) begin
                            state_q <= SEQ_END;
                            pass_q  <= 1'b1;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SEQ_READ;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign idx_o    = idx_q;
    assign wdata_o  = wdata_q;
    assign pass_o   = pass_q;
    assign busy_o   = (state_q != SEQ_IDLE);
    assign done_o   = (state_q == SEQ_END);
    assign req_o    = (state_q == SEQ_READ) || (state_q == SEQ_WRITE);
    assign req_we_o = (state_q == SEQ_WRITE);

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (req_o && !req_we_o && idx_o == '0));

    assert_rd_then_wr_R3: assert property (@(posedge clk) disable iff (rst)
        (req_o && !req_we_o && rsp_done_i && !rsp_bad) |=> (req_o && req_we_o && $stable(idx_o)));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (req_o && !rsp_done_i) |=> (req_o && $stable(req_we_o) && $stable(idx_o) && $stable(wdata_o)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (req_o && rsp_done_i && rsp_bad) |=> (done_o && !pass_o && !req_o));

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && req_o && !rsp_done_i) |=> ($stable(idx_o) && $stable(req_we_o)));
endmodule

// File: rtl/rmw_cfg_seq.sv
module rmw_cfg_seq
    import cfgseq_pkg::*;
#(
    parameter int unsigned ERR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 pass_o,
    output logic                 req_o,
    output logic                 req_we_o,
    output logic [CS_ADDR_W-1:0] req_addr_o,
    output logic [CS_DATA_W-1:0] req_wdata_o,
    input  logic                 rsp_done_i,
    input  logic [CS_DATA_W-1:0] rsp_rdata_i,
    input  logic [ERR_W-1:0]     rsp_err_i
);
    logic [CS_IDX_W-1:0]  idx;
    cfg_entry_t           cur_entry;
    logic [CS_DATA_W-1:0] merged;

    cfgseq_table u_table (
        .idx_i   (idx),
        .entry_o (cur_entry)
    );

    cfgseq_merge u_merge (
        .rdata_i  (rsp_rdata_i),
        .clr_i    (cur_entry.clr),
        .force_i  (cur_entry.force_bits),
        .merged_o (merged)
    );

    cfgseq_ctrl #(.ERR_W(ERR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .rsp_done_i (rsp_done_i),
        .rsp_err_i  (rsp_err_i),
        .merged_i   (merged),
        .idx_o      (idx),
        .wdata_o    (req_wdata_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .pass_o     (pass_o),
        .req_o      (req_o),
        .req_we_o   (req_we_o)
    );

    assign req_addr_o = cur_entry.addr;

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (req_o && !rsp_done_i) |=> (req_o && $stable(req_addr_o)));

    assert_req_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> !req_o);
endmodule

// File: tb/rmw_cfg_seq_tb.sv
`timescale 1ns/1ps
module rmw_cfg_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rsp_done = 1'b0;
    logic [15:0] rsp_rdata = '0;
    logic [2:0]  rsp_err = '0;
    logic        busy, done, pass, req, we;
    logic [7:0]  addr;
    logic [15:0] wdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [15:0] image    [16];
    logic [15:0] init_img [16];
    int          lat = 1;
    int          wcnt = 0;
    int          txn = 0;
    int          err_at = -1;
    logic [2:0]  err_code = 3'd1;

    always #2.5 clk = ~clk;

    rmw_cfg_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start),
        .busy_o(busy), .done_o(done), .pass_o(pass),
        .req_o(req), .req_we_o(we), .req_addr_o(addr), .req_wdata_o(wdata),
        .rsp_done_i(rsp_done), .rsp_rdata_i(rsp_rdata), .rsp_err_i(rsp_err)
    );

    function automatic logic [7:0] tb_addr(input int i);
        case (i) 0: return 8'h06; 1: return 8'h08; 2: return 8'h09; 3: return 8'h0D; default: return 8'h0E; endcase
    endfunction
    function automatic logic [15:0] tb_clr(input int i);
        case (i) 0: return 16'h6017; 1: return 16'h3FFF; 2: return 16'h000F; 3: return 16'h000F; default: return 16'h00FF; endcase
    endfunction
    function automatic logic [15:0] tb_set(input int i);
        case (i) 0: return 16'h2001; 1: return 16'h3FF1; 2: return 16'h0000; 3: return 16'h000B; default: return 16'h0010; endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Behavioural reference: step 0..9 counts transactions, even = read.
    bit          m_busy = 0, m_done = 0, m_pass = 0;
    int          m_step = 0;
    logic [15:0] m_wd = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_pass <= 0; m_step <= 0; m_wd <= '0;
        end else if (m_done) begin
            m_busy <= 0; m_done <= 0;
        end else if (!m_busy) begin
            if (start) begin m_busy <= 1; m_step <= 0; m_pass <= 0; end
        end else if (rsp_done) begin
            if (rsp_err != 0) begin
                m_done <= 1; m_pass <= 0;
            end else if (m_step == 9) begin
                m_done <= 1; m_pass <= 1;
            end else begin
                if (m_step % 2 == 0)
                    m_wd <= (rsp_rdata & ~tb_clr(m_step / 2)) | tb_set(m_step / 2);
                m_step <= m_step + 1;
            end
        end
    end

    // Per-cycle compare, then engine model drives the response.
    always @(negedge clk) begin
        bit m_req;
        if (!rst) begin
            m_req = m_busy && !m_done;
            check(busy == m_busy, "R6", "busy", busy, m_busy);
            check(done == m_done, "R6", "done", done, m_done);
            check(pass == m_pass, "R9", "pass", pass, m_pass);
            check(req == m_req, "R5", "req", req, m_req);
            if (m_req) begin
                check(we == (m_step % 2 == 1), "R3", "write flag", we, m_step % 2);
                check(addr == tb_addr(m_step / 2), "R2/R3", "address", addr, tb_addr(m_step / 2));
                if (m_step % 2 == 1)
                    check(wdata == m_wd, "R4", "write data", wdata, m_wd);
            end
        end
        if (rsp_done) begin
            rsp_done = 1'b0;
            rsp_err  = '0;
            wcnt     = 0;
        end else if (req && !rst) begin
            wcnt++;
            if (wcnt >= lat) begin
                rsp_done = 1'b1;
                rsp_err  = (txn == err_at) ? err_code : 3'd0;
                if (we) begin
                    if (rsp_err == 0) image[addr[3:0]] = wdata;
                end else begin
                    rsp_rdata = image[addr[3:0]];
                end
                txn++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int l, input int ea, input logic [2:0] code);
        lat = l; err_at = ea; err_code = code; txn = 0;
        for (int i = 0; i < 16; i++) init_img[i] = image[i];
        pulse_start();
        wait_end();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) image[i] = 16'hA5A5 ^ (16'(i) * 16'h1111);
        repeat (4) @(negedge clk);
        check(busy == 0 && done == 0 && req == 0 && pass == 0, "R1", "outputs in reset",
              {busy, done, req, pass}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && req == 0 && pass == 0, "R1", "outputs after reset",
              {busy, done, req, pass}, 0);

        // Clean walk, latency 1
        run(1, -1, 3'd0);
        check(pass == 1, "R6", "pass after clean walk", pass, 1);
        check(txn == 10, "R3", "transaction count", txn, 10);
        for (int e = 0; e < 5; e++)
            check(image[tb_addr(e)] == ((init_img[tb_addr(e)] & ~tb_clr(e)) | tb_set(e)), "R4",
                  "register image", image[tb_addr(e)], (init_img[tb_addr(e)] & ~tb_clr(e)) | tb_set(e));
        repeat (5) @(negedge clk);
        check(pass == 1, "R9", "pass held while idle", pass, 1);

        // All-ones image, latency 3, extra start while busy
        for (int i = 0; i < 16; i++) image[i] = 16'hFFFF;
        for (int i = 0; i < 16; i++) init_img[i] = image[i];
        lat = 3; err_at = -1; txn = 0;
        pulse_start();
        check(pass == 0, "R9", "pass cleared by start", pass, 0);
        repeat (4) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_end();
        check(txn == 10, "R8", "transactions with extra start", txn, 10);
        check(pass == 1, "R6", "pass after slow walk", pass, 1);
        repeat (6) @(negedge clk);
        check(busy == 0 && txn == 10, "R8", "no second run queued", busy, 0);
        check(image[8'h08] == 16'hFFF1, "R4", "0x08 from all ones", image[8'h08], 16'hFFF1);
        check(image[8'h0E] == 16'hFF10, "R4", "0x0E from all ones", image[8'h0E], 16'hFF10);

        // Error on the write of 0x08
        for (int i = 0; i < 16; i++) image[i] = 16'h1234 + 16'(i);
        run(2, 3, 3'd5);
        check(pass == 0, "R7", "pass after mid error", pass, 0);
        check(txn == 4, "R7", "transactions before abort", txn, 4);
        repeat (10) @(negedge clk);
        check(txn == 4 && req == 0, "R7", "no request after abort", txn, 4);
        check(image[8'h08] == init_img[8'h08], "R7", "0x08 untouched", image[8'h08], init_img[8'h08]);
        check(image[8'h09] == init_img[8'h09], "R7", "0x09 untouched", image[8'h09], init_img[8'h09]);

        // Error on the first read
        run(1, 0, 3'd1);
        check(pass == 0 && txn == 1, "R7", "abort on first read", txn, 1);
        check(image[8'h06] == init_img[8'h06], "R7", "0x06 untouched", image[8'h06], init_img[8'h06]);

        // Error on the last write
        run(1, 9, 3'd7);
        check(pass == 0 && txn == 10, "R7", "abort on last write", txn, 10);
        check(image[8'h0E] == init_img[8'h0E], "R7", "0x0E untouched", image[8'h0E], init_img[8'h0E]);
        check(image[8'h0D] == ((init_img[8'h0D] & ~16'h000F) | 16'h000B), "R4", "0x0D merged",
              image[8'h0D], (init_img[8'h0D] & ~16'h000F) | 16'h000B);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule